// File: doc/BRIEF.md
# Iterative Leading-One Multiplier

This block multiplies two unsigned operands with leading-one detection, shifts and additions instead of an array multiplier. Each operand is treated as its top power of two plus a remainder, A = 2^j + AR and B = 2^k + BR. One pass adds 2^(j+k) + (BR << j) + (AR << k) into an accumulator. The cross term AR*BR is what remains, and the next pass splits the two remainders in the same way.

A caller pulses `start` with both operands and an iteration cap. The block runs one pass per clock and stops at the first of two events: the cap is reached, or the leftover cross term is known without another pass. In the second case the result is exact. A low cap gives a quick result that is always an underestimate. A cap of 7 always gives the full product for 8-bit operands. The caller trades cycles against accuracy per operation.

Top module: `logmul_iter`

## Requirements
- R1: If either operand is 0 when `start` is sampled, `done` is high after that same rising edge, with `product` = 0 and `exact` = 1.
- R2: With `iter_cap` = 7, every operand pair yields `product` equal to the true product and `exact` = 1.
- R3: With any cap, the reported `product` never exceeds the true product.
- R4: `exact` is 1 exactly when the reported `product` equals the true product.
- R5: One pass runs per clock. With nonzero operands and N passes, `done` is high after the N-th rising edge that follows the edge sampling `start`. N is the smaller of the cap and the pass count at which the leftover term vanishes. A pass ends the run exactly when both remainders are at most 1, or when either remainder is 0.
- R6: After c completed passes, with c limited by the cap, (true − product) × 4^c ≤ true. This means at most −25%, −6.25% and −1.6% error after one, two and three passes.
- R7: `done` is a single-cycle pulse. `product` and `exact` keep their value until the next completion.
- R8: An `iter_cap` of 0 behaves as a cap of 1.
- R9: A `start` that arrives while a run is in progress abandons that run and begins the new one.
- R10: While reset is applied, `done`, `product` and `exact` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle request that samples the operands and cap |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| iter_cap | input | 3 | Largest number of passes allowed (0 treated as 1) |
| product | output | 16 | Accumulated product, held between completions |
| done | output | 1 | One-cycle completion pulse |
| exact | output | 1 | Result equals the true product |

## Verification
The in-line assertions check several properties on every cycle. `done` lasts one cycle, and the result registers change only at completion. A zero operand completes immediately with an exact zero. The pass counter stays below the cap. The accumulator never falls during a run. Accuracy, on the other hand, needs the operands and the true product. Only the bench scenarios show it: exactness at cap 7 over a wide operand grid, the underestimate and error bounds at caps 1 to 3, the agreement of the flag with the result, the latency per pass, and the restart behaviour.

// File: rtl/logmul_pkg.sv
package logmul_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_e;
endpackage

// File: rtl/logmul_lead1.sv
module logmul_lead1 #(
  parameter int W = 8
) (
  input  logic [W-1:0]         vec,
  output logic [$clog2(W)-1:0] pos
);
  localparam int PW = $clog2(W);

  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = PW'(i);
    end
  end
endmodule

// File: rtl/logmul_step.sv
module logmul_step #(
  parameter int W = 8
) (
  input  logic [W-1:0]   ra,
  input  logic [W-1:0]   rb,
  output logic [2*W-1:0] term,
  output logic [W-1:0]   ar,
  output logic [W-1:0]   br,
  output logic           stop_exact
);
  localparam int PW = $clog2(W);
  localparam int DW = 2 * W;

  logic [PW-1:0] ja, kb;
  logic [PW:0]   sh;
  logic          tiny;
  logic          tail;

  logmul_lead1 #(.W(W)) u_lod_a (.vec(ra), .pos(ja));
  logmul_lead1 #(.W(W)) u_lod_b (.vec(rb), .pos(kb));

  always_comb begin
    ar   = ra & ~(W'(1) << ja);
    br   = rb & ~(W'(1) << kb);
    sh   = {1'b0, ja} + {1'b0, kb};
    tiny = (ar[W-1:1] == '0) && (br[W-1:1] == '0);
    tail = tiny & ar[0] & br[0];
    term = (DW'(1) << sh) + (DW'(br) << ja) + (DW'(ar) << kb) + DW'(tail);
    stop_exact = (ar == '0) || (br == '0) || tiny;
  end
endmodule

// File: rtl/logmul_iter.sv
module logmul_iter
  import logmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [W-1:0]           op_a,
  input  logic [W-1:0]           op_b,
  input  logic [$clog2(W)-1:0]   iter_cap,
  output logic [2*W-1:0]         product,
  output logic                   done,
  output logic                   exact
);
  localparam int CW = $clog2(W);
  localparam int DW = 2 * W;

  // reset synchronizer: assert async, release on clock
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  // state
  run_e          run_q, run_d;
  logic [W-1:0]  ra_q, ra_d, rb_q, rb_d;
  logic [DW-1:0] acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic [DW-1:0] prod_q, prod_d;
  logic          exact_q, exact_d, done_q, done_d;
  logic          op_en, res_en, cap_en;

  // one pass of decomposition
  logic [DW-1:0] term, sum;
  logic [W-1:0]  ar, br;
  logic          stop_exact;
  logic [CW-1:0] cnt_nx;
  logic          zero_in, go;

  logmul_step #(.W(W)) u_step (
    .ra(ra_q), .rb(rb_q), .term(term), .ar(ar), .br(br), .stop_exact(stop_exact)
  );

  always_comb begin
    zero_in = (op_a == '0) || (op_b == '0);
    go      = start && !zero_in;
    sum     = acc_q + term;
    cnt_nx  = cnt_q + 1'b1;

    run_d   = run_q;
    ra_d    = ra_q;
    rb_d    = rb_q;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    cap_d   = cap_q;
    prod_d  = prod_q;
    exact_d = exact_q;
    done_d  = 1'b0;
    op_en   = 1'b0;
    res_en  = 1'b0;
    cap_en  = 1'b0;

    if (start) begin
      if (zero_in) begin
        run_d   = RUN_IDLE;
        prod_d  = '0;
        exact_d = 1'b1;
        done_d  = 1'b1;
        res_en  = 1'b1;
      end else begin
        run_d  = RUN_BUSY;
        ra_d   = op_a;
        rb_d   = op_b;
        acc_d  = '0;
        cnt_d  = '0;
        cap_d  = (iter_cap == '0) ? CW'(1) : iter_cap;
        op_en  = 1'b1;
        cap_en = 1'b1;
      end
    end else if (run_q == RUN_BUSY) begin
      if (stop_exact || (cnt_nx == cap_q)) begin
        run_d   = RUN_IDLE;
        prod_d  = sum;
        exact_d = stop_exact;
        done_d  = 1'b1;
        res_en  = 1'b1;
      end else begin
        ra_d  = ar;
        rb_d  = br;
        acc_d = sum;
        cnt_d = cnt_nx;
        op_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q   <= RUN_IDLE;
      done_q  <= 1'b0;
      ra_q    <= '0;
      rb_q    <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      cap_q   <= CW'(1);
      prod_q  <= '0;
      exact_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      if (op_en) begin
        ra_q  <= ra_d;
        rb_q  <= rb_d;
        acc_q <= acc_d;
        cnt_q <= cnt_d;
      end
      if (cap_en) cap_q <= cap_d;
      if (res_en) begin
        prod_q  <= prod_d;
        exact_q <= exact_d;
      end
    end
  end

  assign product = prod_q;
  assign done    = done_q;
  assign exact   = exact_q;

  // R1: zero operand finishes at once with an exact zero
  a_r1_zero_now: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start && ((op_a == '0) || (op_b == '0)) |=> done && (product == '0) && exact);

  // R7: completion pulse lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done && !start |=> !done);

  // R7: result registers move only together with done
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done |-> (product == $past(product)) && (exact == $past(exact)));

  // R5: pass counter never reaches the cap while running
  a_r5_cnt_below_cap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q == RUN_BUSY) |-> (cnt_q < cap_q) && (cap_q != '0));

  // R3: partial sum only grows within one run
  a_r3_acc_grows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q == RUN_BUSY) && $past(run_q == RUN_BUSY) && !$past(start) |-> acc_q >= $past(acc_q));
endmodule

// File: tb/logmul_iter_bench.sv
module logmul_iter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic [2:0]  iter_cap = '0;
  logic [15:0] product;
  logic        done;
  logic        exact;

  logmul_iter u_logmul_iter (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .iter_cap(iter_cap), .product(product), .done(done), .exact(exact)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  b;
    logic [2:0]  cap;
    logic [15:0] prod;
    logic        ex;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{8'd0,   8'd77,  3'd3, 16'd0,     1'b1, 4'd1},  // R1
    '{8'd77,  8'd0,   3'd3, 16'd0,     1'b1, 4'd1},  // R1
    '{8'd1,   8'd1,   3'd1, 16'd1,     1'b1, 4'd2},
    '{8'd255, 8'd255, 3'd7, 16'd65025, 1'b1, 4'd8},  // R2 worst case, 7 passes
    '{8'd200, 8'd100, 3'd1, 16'd17408, 1'b0, 4'd2},
    '{8'd128, 8'd3,   3'd1, 16'd384,   1'b1, 4'd2},
    '{8'd6,   8'd6,   3'd1, 16'd32,    1'b0, 4'd2},
    '{8'd6,   8'd6,   3'd2, 16'd36,    1'b1, 4'd3},
    '{8'd6,   8'd6,   3'd0, 16'd32,    1'b0, 4'd2},  // R8
    '{8'd3,   8'd3,   3'd7, 16'd9,     1'b1, 4'd2},
    '{8'd255, 8'd255, 3'd1, 16'd48896, 1'b0, 4'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic run(input int a, input int b, input int cap,
                     output int p, output bit ex, output int lat);
    @(negedge clk);
    op_a = a[7:0]; op_b = b[7:0]; iter_cap = cap[2:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    p  = int'(product);
    ex = exact;
  endtask

  function automatic int drop_top(input int v);
    int t = 0;
    for (int i = 0; i < 8; i++) if (v[i]) t = i;
    return v - (1 << t);
  endfunction

  function automatic int passes(input int a, input int b);
    int x = a, y = b, n = 0;
    if (a == 0 || b == 0) return 0;
    while (1) begin
      n++;
      x = drop_top(x);
      y = drop_top(y);
      if (x == 0 || y == 0 || (x <= 1 && y <= 1)) return n;
    end
  endfunction

  function automatic int exp_lat(input int a, input int b, input int cap);
    int n = passes(a, b);
    int c = (cap == 0) ? 1 : cap;
    if (n == 0) return 1;
    return ((n < c) ? n : c) + 1;
  endfunction

  initial begin
    int p, lat, held;
    bit ex;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R10", "done in reset", int'(done), 0);
    chk(product == 16'd0, "R10", "product in reset", int'(product), 0);
    chk(exact == 1'b0, "R10", "exact in reset", int'(exact), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed vectors: R1 R2 R5 R8 values and latency
    for (int i = 0; i < NV; i++) begin
      run(int'(TBL[i].a), int'(TBL[i].b), int'(TBL[i].cap), p, ex, lat);
      chk(p == int'(TBL[i].prod), "R2", $sformatf("table %0d product", i), p, int'(TBL[i].prod));
      chk(ex == TBL[i].ex, "R4", $sformatf("table %0d exact", i), int'(ex), int'(TBL[i].ex));
      chk(lat == int'(TBL[i].lat), "R5", $sformatf("table %0d latency", i), lat, int'(TBL[i].lat));
    end

    // R7: done drops after one cycle, result held while idle and during the next run
    run(200, 100, 1, p, ex, lat);
    held = p;
    @(negedge clk);
    chk(done == 1'b0, "R7", "done pulse width", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(int'(product) == held, "R7", "product held idle", int'(product), held);
    @(negedge clk);
    op_a = 8'd255; op_b = 8'd255; iter_cap = 3'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(int'(product) == held, "R7", "product held mid-run", int'(product), held);
    chk(exact == 1'b0, "R7", "exact held mid-run", int'(exact), 0);
    while (!done) @(negedge clk);

    // R9: restart while busy
    @(negedge clk);
    op_a = 8'd255; op_b = 8'd255; iter_cap = 3'd7; start = 1'b1;
    @(negedge clk);
    op_a = 8'd6; op_b = 8'd6; iter_cap = 3'd2;
    run(6, 6, 2, p, ex, lat);
    chk(p == 36, "R9", "restart product", p, 36);
    chk(ex == 1'b1, "R9", "restart exact", int'(ex), 1);
    chk(lat == 3, "R9", "restart latency", lat, 3);

    // R2 R5: cap 7 gives the true product on a wide grid
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 9) begin
        run(a, b, 7, p, ex, lat);
        chk(p == a * b, "R2", $sformatf("%0d*%0d", a, b), p, a * b);
        chk(ex == 1'b1, "R2", $sformatf("%0d*%0d exact", a, b), int'(ex), 1);
        chk(lat == exp_lat(a, b, 7), "R5", $sformatf("%0d*%0d latency", a, b), lat, exp_lat(a, b, 7));
      end
    end

    // R3 R4 R6: truncated runs
    for (int cap = 1; cap <= 3; cap++) begin
      for (int a = 1; a < 256; a += 5) begin
        for (int b = 3; b < 256; b += 13) begin
          int tru, c, n;
          run(a, b, cap, p, ex, lat);
          tru = a * b;
          n = passes(a, b);
          c = (n < cap) ? n : cap;
          chk(p <= tru, "R3", $sformatf("%0d*%0d cap %0d bound", a, b, cap), p, tru);
          chk(ex == (p == tru), "R4", $sformatf("%0d*%0d cap %0d flag", a, b, cap), int'(ex), int'(p == tru));
          chk((tru - p) * (1 << (2 * c)) <= tru, "R6", $sformatf("%0d*%0d cap %0d error", a, b, cap), p, tru);
          chk(lat == c + 1, "R5", $sformatf("%0d*%0d cap %0d latency", a, b, cap), lat, c + 1);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule